// File: doc/BRIEF.md
# Power Bus Command Sequence Transmitter

This block is the controller side of a two-wire serial bus used to reach power-management devices. It generates the bus clock and drives the bidirectional data line, modelled as three separate signals: data out, output enable and data in. It sends one complete command sequence per request. Each sequence has five parts: a start pattern, a 13-bit command frame, zero to fifteen 9-bit data frames, an acknowledge slot sampled from the target, and a park cycle. After the park cycle the data line is released.

The user side offers a 4-bit target address, an 8-bit command code and a byte count through a valid/ready handshake. The data bytes follow one at a time on a second valid/ready handshake. When the sequence is finished the block pulses a done flag and presents the acknowledge result with it. The bus bit rate is set by the parameter `HALF_DIV`, the number of system clocks in each half of a bus clock period. A ratio of 1 to 2 suits rates near the fast class limit; values in the thousands reach the 32 kHz end of the range.

Top module: `pbus_cmd_tx`

## Requirements
- R1: After reset and between sequences, `sclk` is low, `sdata_oe` is low, `done` is low and `cmd_ready` is high.
- R2: A sequence opens with a start pattern during which `sclk` stays low and the data line is driven. The line is high for one bit period (2·HALF_DIV clocks), then low for one bit period.
- R3: The command frame is sent most-significant bit first as 13 bits: the 4-bit address, then the 8-bit command code, then one odd-parity bit, so that the 13 bits together hold an odd number of ones.
- R4: `cmd_nbytes` data frames (0 to 15) follow the command frame. Each carries the next accepted byte, MSB first, then an odd-parity bit. Bytes are sent in the order they were accepted.
- R5: Each bit is presented on the rising edge of `sclk`. The data line holds its value until the next rising edge. `sclk` stays high for exactly HALF_DIV clocks, so a bit period is 2·HALF_DIV clocks.
- R6: In the acknowledge slot, `sdata_oe` is low for one bit period. `sdata_i` is sampled when `sclk` falls: 1 reports ack=1; 0, or a line that nothing drives (pulled low), reports ack=0.
- R7: The park cycle drives the data line low for one bit period with one clock pulse. `sdata_oe` is low from the cycle in which `done` rises.
- R8: `done` is a one-cycle pulse with `ack` valid in that cycle. If each byte is offered before it is needed, it comes 2·HALF_DIV·(17+9·N)+N clocks after the request is accepted.
- R9: If no byte is offered at a frame boundary, the block waits with `dat_ready` high, `sclk` held low and the data line held. The sequence resumes intact, one clock after the byte is accepted.
- R10: `cmd_valid` and the command fields are ignored while a sequence is in progress (`cmd_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Idle, request can be taken |
| cmd_addr | input | 4 | Target address |
| cmd_code | input | 8 | Command code |
| cmd_nbytes | input | CNT_W | Number of data frames |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte wanted now |
| dat_byte | input | 8 | Data byte |
| done | output | 1 | Sequence finished (one cycle) |
| ack | output | 1 | Acknowledge result, valid with done |
| sclk | output | 1 | Bus clock |
| sdata_o | output | 1 | Data line value when driven |
| sdata_oe | output | 1 | Data line drive enable |
| sdata_i | input | 1 | Data line as seen on the pad |

## Verification
The start pattern lasts exactly 4·HALF_DIV clocks from the accepting edge, so the bench checks it cycle by cycle. Every later bit is captured at the rising `sclk` seen one sample after the register edge, and the high time is counted against HALF_DIV. The done pulse is due 2·HALF_DIV·(17+9·N)+N clocks after acceptance, plus each clock a byte was held back. The bench counts clocks from the accepting edge and compares at the half-cycle sample after `done` rises. The target model drives `sdata_i` from the sample after the acknowledge rise until the fall, which covers the sampling edge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ADDR_W  = 4;
  localparam int CODE_W  = 8;
  localparam int BYTE_W  = 8;
  localparam int CMD_LEN = ADDR_W + CODE_W + 1;
  localparam int DAT_LEN = BYTE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SSC_HI, ST_SSC_LO, ST_SHIFT, ST_LOAD, ST_ACK, ST_PARK
  } seq_st_t;
endpackage

// File: rtl/pbus_halfclk.sv
module pbus_halfclk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  // R5: the half-period counter never passes its terminal value
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/pbus_framer.sv
module pbus_framer
  import pbus_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_cmd,
  input  logic [ADDR_W+CODE_W-1:0] cmd_bits,
  input  logic                     ld_dat,
  input  logic [BYTE_W-1:0]        dat,
  input  logic                     shift,
  output logic                     bit_o,
  output logic                     nxt_o,
  output logic                     last_o
);
  localparam int LW = $clog2(CMD_LEN + 1);

  logic [CMD_LEN-1:0] sr;
  logic [LW-1:0]      left;

  assign bit_o  = sr[CMD_LEN-1];
  assign nxt_o  = sr[CMD_LEN-2];
  assign last_o = (left == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (ld_cmd) begin
      sr   <= {cmd_bits, ~^cmd_bits};                       // R3 odd parity
      left <= LW'(CMD_LEN);
    end else if (ld_dat) begin
      sr   <= {dat, ~^dat, {(CMD_LEN-DAT_LEN){1'b0}}};       // R4 odd parity
      left <= LW'(DAT_LEN);
    end else if (shift && left != '0) begin
      sr   <= {sr[CMD_LEN-2:0], 1'b0};
      left <= left - LW'(1);
    end
  end

  // R3: remaining-bit count stays within one command frame
  a_r3_left_range: assert property (@(posedge clk) disable iff (rst)
    left <= LW'(CMD_LEN));
endmodule

// File: rtl/pbus_cmd_tx.sv
module pbus_cmd_tx
  import pbus_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [CNT_W-1:0]  cmd_nbytes,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [BYTE_W-1:0] dat_byte,
  output logic              done,
  output logic              ack,
  output logic              sclk,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i
);
  seq_st_t          st;
  logic             ph;
  logic [CNT_W-1:0] bytes_left;
  logic             tick, run;
  logic             accept, take;
  logic             frm_bit, frm_nxt, frm_last;

  assign cmd_ready = (st == ST_IDLE);
  assign dat_ready = (st == ST_LOAD);
  // R10: requests are only taken while idle
  assign accept    = cmd_valid && cmd_ready;
  assign take      = dat_valid && dat_ready;
  assign run       = (st != ST_IDLE) && (st != ST_LOAD);

  pbus_halfclk #(.HALF_DIV(HALF_DIV)) u_div (
    .clk (clk), .rst (rst), .run (run), .tick (tick)
  );

  pbus_framer u_frm (
    .clk      (clk),
    .rst      (rst),
    .ld_cmd   (accept),
    .cmd_bits ({cmd_addr, cmd_code}),
    .ld_dat   (take),
    .dat      (dat_byte),
    .shift    ((st == ST_SHIFT) && tick && ph),
    .bit_o    (frm_bit),
    .nxt_o    (frm_nxt),
    .last_o   (frm_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph         <= 1'b0;
      bytes_left <= '0;
      sclk       <= 1'b0;
      sdata_o    <= 1'b0;
      sdata_oe   <= 1'b0;
      done       <= 1'b0;
      ack        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) ph <= ~ph;
      case (st)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (accept) begin
            st         <= ST_SSC_HI;
            ph         <= 1'b0;
            sdata_o    <= 1'b1;
            sdata_oe   <= 1'b1;
            bytes_left <= cmd_nbytes;
          end
        end
        ST_SSC_HI: if (tick && ph) begin
          st      <= ST_SSC_LO;
          sdata_o <= 1'b0;
        end
        ST_SSC_LO: if (tick && ph) begin
          st      <= ST_SHIFT;
          sclk    <= 1'b1;
          sdata_o <= frm_bit;
        end
        ST_SHIFT: if (tick) begin
          if (!ph) sclk <= 1'b0;
          else if (!frm_last) begin
            sclk    <= 1'b1;
            sdata_o <= frm_nxt;
          end else if (bytes_left != '0) begin
            st <= ST_LOAD;                       // R9: clock parks low
          end else begin
            st       <= ST_ACK;
            sclk     <= 1'b1;
            sdata_oe <= 1'b0;
          end
        end
        ST_LOAD: if (take) begin
          st         <= ST_SHIFT;
          ph         <= 1'b0;
          sclk       <= 1'b1;
          sdata_o    <= dat_byte[BYTE_W-1];
          bytes_left <= bytes_left - CNT_W'(1);
        end
        ST_ACK: if (tick) begin
          if (!ph) begin
            sclk <= 1'b0;
            ack  <= sdata_i;                     // R6 sample at falling edge
          end else begin
            st       <= ST_PARK;
            sclk     <= 1'b1;
            sdata_o  <= 1'b0;
            sdata_oe <= 1'b1;
          end
        end
        ST_PARK: if (tick) begin
          if (!ph) sclk <= 1'b0;
          else begin
            st       <= ST_IDLE;
            sdata_oe <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !sclk);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_release_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !sdata_oe);
  a_r9_wait_clk_low: assert property (@(posedge clk) disable iff (rst)
    dat_ready |-> !sclk);
  a_r5_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata_o));
endmodule

// File: tb/sim_pbus_cmd_tx.sv
module sim_pbus_cmd_tx;
  localparam int CLK_PER = 10;
  localparam int H       = 4;
  localparam int WD      = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid, cmd_ready;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_code;
  logic [3:0] cmd_nbytes;
  logic       dat_valid, dat_ready;
  logic [7:0] dat_byte;
  logic       done, ack, sclk, sdata_o, sdata_oe, sdata_i;
  logic       sdi_drv, sdi_val;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] tx_bytes [16];

  assign sdata_i = sdi_drv ? sdi_val : 1'b0;   // pull-down when undriven

  pbus_cmd_tx #(.HALF_DIV(H), .CNT_W(4)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_nbytes(cmd_nbytes),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .done(done), .ack(ack), .sclk(sclk), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .sdata_i(sdata_i)
  );

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [11:0] v, input int w);
    int ones = 0;
    for (int i = 0; i < w; i++) ones += int'(v[i]);
    return (ones % 2 == 0);
  endfunction

  function automatic int exp_latency(input int n, input int k);
    return 2 * H * (17 + 9 * n) + n + n * k;
  endfunction

  task automatic run_seq(input logic [3:0] a, input logic [7:0] c, input int n,
                         input int ackm, input int stall_k, input bit junk);
    int  t0 = 0, td = 0, k = 0, hcnt = 0, wait_cnt = 0;
    int  ack_idx = 13 + 9 * n;
    bit  ssc_ok = 1, width_ok = 1, stab_ok = 1, wait_ok = 1, seen = 0;
    bit  ack_got = 0, oe_done = 1;
    logic bits [160];
    logic oes  [160];
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_code = c; cmd_nbytes = 4'(n);
    while (!cmd_ready) @(negedge clk);
    t0 = cyc + 1;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if (stall_k > 0) begin
            while (!dat_ready) @(negedge clk);
            repeat (stall_k) @(negedge clk);
          end else @(negedge clk);
          dat_valid = 1; dat_byte = tx_bytes[i];
          while (!dat_ready) @(negedge clk);
          @(negedge clk);
          dat_valid = 0; dat_byte = 8'($urandom);
        end
      end
      begin
        logic ps, pd, po;
        for (int q = 0; q < 4 * H; q++) begin
          @(negedge clk);
          if (q == 0) begin
            if (junk) begin
              cmd_addr = 4'($urandom); cmd_code = 8'($urandom); cmd_nbytes = 4'($urandom);
            end else cmd_valid = 0;
          end
          if (!(sclk == 0 && sdata_oe == 1 && sdata_o == (q < 2 * H))) ssc_ok = 0;
        end
        ps = sclk; pd = sdata_o; po = sdata_oe;
        while (!seen) begin
          @(negedge clk);
          if (sclk && !ps) begin
            bits[k] = sdata_o; oes[k] = sdata_oe;
            if (k == ack_idx && ackm != 2) begin sdi_drv = 1; sdi_val = (ackm == 1); end
            if (k == ack_idx + 1) cmd_valid = 0;
            k++; hcnt = 1;
          end else begin
            if (sclk) hcnt++;
            if (!sclk && ps) begin
              if (hcnt != H) width_ok = 0;
              sdi_drv = 0;
            end
            if (po && sdata_oe && sdata_o != pd) stab_ok = 0;
          end
          if (dat_ready) begin wait_cnt++; if (sclk) wait_ok = 0; end
          if (done) begin td = cyc; ack_got = ack; oe_done = sdata_oe; seen = 1; end
          ps = sclk; pd = sdata_o; po = sdata_oe;
        end
      end
    join
    check(ssc_ok, "R2 start pattern", ssc_ok, 1);
    begin
      logic [12:0] got = '0, exp;
      exp = {a, c, odd_bit({a, c}, 12)};
      for (int i = 0; i < 13; i++) got[12-i] = bits[i];
      check(got == exp, junk ? "R3/R10 command frame (busy request ignored)" : "R3 command frame", got, exp);
    end
    for (int f = 0; f < n; f++) begin
      logic [8:0] g = '0, e;
      e = {tx_bytes[f], odd_bit({4'b0, tx_bytes[f]}, 8)};
      for (int i = 0; i < 9; i++) g[8-i] = bits[13 + 9 * f + i];
      check(g == e, "R4 data frame", g, e);
    end
    check(k == ack_idx + 2, "R4 clock pulse count", k, ack_idx + 2);
    check(width_ok && stab_ok, "R5 clock high width and data hold", {width_ok, stab_ok}, 2'b11);
    check(oes[ack_idx] == 0 && ack_got == (ackm == 1), "R6 ack slot release and result",
          {oes[ack_idx], ack_got}, {1'b0, ackm == 1});
    check(bits[ack_idx+1] == 0 && oes[ack_idx+1] == 1 && oe_done == 0, "R7 park and release",
          {bits[ack_idx+1], oes[ack_idx+1], oe_done}, 3'b010);
    check(td - t0 == exp_latency(n, stall_k), "R8 done latency", td - t0, exp_latency(n, stall_k));
    check(wait_ok && wait_cnt == n * (stall_k + 1), "R9 byte wait with clock low",
          wait_cnt, n * (stall_k + 1));
    @(negedge clk);
    check(!done && !sclk && !sdata_oe && cmd_ready, "R1/R8 idle after single done pulse",
          {done, sclk, sdata_oe, cmd_ready}, 4'b0001);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst = 1; cmd_valid = 0; cmd_addr = 0; cmd_code = 0; cmd_nbytes = 0;
    dat_valid = 0; dat_byte = 0; sdi_drv = 0; sdi_val = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cmd_ready && !sclk && !sdata_oe && !done && !dat_ready, "R1 reset state",
          {cmd_ready, sclk, sdata_oe, done, dat_ready}, 5'b10000);

    run_seq(4'hF, 8'hA5, 0, 1, 0, 0);
    tx_bytes[0] = 8'h00;
    run_seq(4'h0, 8'h00, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) tx_bytes[i] = 8'hFF;
    run_seq(4'h5, 8'hFF, 15, 2, 0, 0);
    tx_bytes[0] = 8'h3C; tx_bytes[1] = 8'h81; tx_bytes[2] = 8'h7E;
    run_seq(4'h3, 8'h3C, 3, 1, 5, 0);   // R9 stall at every boundary
    tx_bytes[0] = 8'h12; tx_bytes[1] = 8'hEF;
    run_seq(4'hA, 8'h96, 2, 1, 0, 1);   // R10 request held during busy

    for (int r = 0; r < 20; r++) begin
      int n = $urandom_range(0, 4);
      int am = $urandom_range(0, 2);
      int sk = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 6) : 0;
      bit jk = 1'($urandom_range(0, 1));
      for (int i = 0; i < n; i++) tx_bytes[i] = 8'($urandom);
      run_seq(4'($urandom), 8'($urandom), n, am, sk, jk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule